// File: doc/BRIEF.md
# Descriptor Rights and Limit Query Unit

This block answers the two inspection queries that unprivileged software issues against a segment descriptor. One asks for the access-rights word. The other asks for the byte-granular segment limit. The descriptor fetch happens outside the block. The caller presents the two 32-bit descriptor words, the requester level taken from the selector, the current privilege level, and a flag that says the selector lies beyond its descriptor table. A one-bit query kind picks which answer is wanted.

One clock after a request, the unit returns four outputs:
- a response strobe;
- a success flag, which the core copies into its zero flag;
- a write enable for the destination register;
- a 32-bit result.

A query fails in any of these cases: the selector lies outside the table, the descriptor is not visible at the requesting level, or the descriptor type is not valid for that kind of query. On failure the destination is left untouched.

Top module: `dq_query_unit`

## Requirements
- R1: Each cycle with `req_valid` high yields exactly one cycle of `rsp_valid` on the next clock. No response appears without a request.
- R2: When `beyond_table` is high, the query fails, whatever the descriptor holds.
- R3: Let the requesting level be the larger of `cur_cpl` and `sel_rpl`. A descriptor is visible only if its DPL (word 1 bits 14:13) is at least that level. The exception is a conforming code segment (bit 12 = 1, bit 11 = 1, bit 10 = 1), which is visible from any level.
- R4: A successful rights query (`query_kind` = 0) returns word 1 ANDed with 0x00FFFF00.
- R5: For a rights query, every code or data descriptor (bit 12 = 1) passes the type screen. Of the system types (word 1 bits 11:8 with bit 12 = 0), only 1, 2, 3, 4, 5, 9, 11 and 12 pass.
- R6: For a limit query (`query_kind` = 1), every code or data descriptor passes the type screen. Of the system types, only 1, 2, 3, 9 and 11 pass; every gate type and the reserved codes 0, 8, 10 and 13 fail.
- R7: A successful limit query with G (word 1 bit 23) = 0 returns the 20-bit limit zero-extended. The limit is word 1 bits 19:16 above word 0 bits 15:0.
- R8: A successful limit query with G = 1 returns the 20-bit limit shifted left by 12, with the low 12 bits set to one.
- R9: A failed query drives `rsp_ok` = 0, `rsp_write` = 0 and `rsp_data` = 0. A successful one drives `rsp_ok` = 1 and `rsp_write` = 1.
- R10: While `rst_n` is low, all outputs are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Query presented this cycle |
| query_kind | input | 1 | 0 = access rights, 1 = segment limit |
| desc_lo | input | 32 | Descriptor word 0 |
| desc_hi | input | 32 | Descriptor word 1 |
| sel_rpl | input | 2 | Requester level from the selector |
| cur_cpl | input | 2 | Current privilege level |
| beyond_table | input | 1 | Selector exceeds the table limit |
| rsp_valid | output | 1 | Response strobe |
| rsp_ok | output | 1 | Query succeeded (zero flag value) |
| rsp_write | output | 1 | Destination register write enable |
| rsp_data | output | 32 | Rights word or expanded limit |

## Verification
Every result, the success flag and the write enable, is registered once. All of them are due exactly one clock after the request that caused them, and back-to-back requests produce back-to-back responses.

The driver stamps each expected item with the cycle number in which the response must appear. The monitor samples the outputs a little after the falling edge. It compares both the values and the stamped cycle, so an early, late, missing or spurious response shows up as an error. At the end, a drained-queue check catches any response that never arrived.

// File: rtl/dq_pkg.sv
package dq_pkg;

  typedef enum logic {
    Q_RIGHTS = 1'b0,
    Q_LIMIT  = 1'b1
  } query_e;

  // Fields of descriptor word 1 that steer the query.
  typedef struct packed {
    logic       gran;
    logic [1:0] dpl;
    logic       is_seg;
    logic [3:0] tcode;
  } attr_t;

  function automatic attr_t f_attr(input logic [31:0] w1);
    attr_t a;
    a.gran   = w1[23];
    a.dpl    = w1[14:13];
    a.is_seg = w1[12];
    a.tcode  = w1[11:8];
    return a;
  endfunction

  function automatic logic [1:0] f_weaker(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dq_visibility.sv
module dq_visibility #(
  parameter int unsigned PLW = 2
) (
  input  logic [PLW-1:0] cpl,
  input  logic [PLW-1:0] rpl,
  input  logic [PLW-1:0] dpl,
  input  logic           conforming,
  output logic           visible
);
  logic [PLW-1:0] req_level;

  always_comb begin
    req_level = (cpl > rpl) ? cpl : rpl;
    visible   = conforming || (req_level <= dpl);
  end
endmodule

// File: rtl/dq_type_screen.sv
module dq_type_screen #(
  parameter int unsigned CODE_W = 4,
  parameter logic [(1<<CODE_W)-1:0] SYS_OK = '0
) (
  input  logic              is_seg,
  input  logic [CODE_W-1:0] tcode,
  output logic              pass
);
  localparam int unsigned N_CODES = 1 << CODE_W;

  logic [N_CODES-1:0] hit;

  // One-hot decode of the system type code, gated by the table.
  for (genvar i = 0; i < N_CODES; i++) begin : g_code
    assign hit[i] = SYS_OK[i] && (tcode == CODE_W'(i));
  end

  assign pass = is_seg || (|hit);
endmodule

// File: rtl/dq_limit_build.sv
module dq_limit_build #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LO_W  = 16,
  parameter int unsigned HI_W  = 4,
  parameter int unsigned SHIFT = 12
) (
  input  logic [LO_W-1:0] lo_part,
  input  logic [HI_W-1:0] hi_part,
  input  logic            gran,
  output logic [DW-1:0]   limit
);
  localparam int unsigned LIM_W = LO_W + HI_W;

  function automatic logic [DW-1:0] f_expand(input logic [LIM_W-1:0] raw, input logic g);
    logic [DW-1:0] wide;
    logic [DW-1:0] fill;
    wide = DW'(raw);
    fill = (DW'(1) << SHIFT) - DW'(1);
    return g ? ((wide << SHIFT) | fill) : wide;
  endfunction

  assign limit = f_expand({hi_part, lo_part}, gran);
endmodule

// File: rtl/dq_query_unit.sv
module dq_query_unit
  import dq_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned PLW         = 2,
  parameter logic [31:0] RIGHTS_MASK = 32'h00FF_FF00,
  parameter logic [15:0] RIGHTS_SYS  = 16'h1A3E,
  parameter logic [15:0] LIMIT_SYS   = 16'h0A0E
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           query_kind,
  input  logic [DW-1:0]  desc_lo,
  input  logic [DW-1:0]  desc_hi,
  input  logic [PLW-1:0] sel_rpl,
  input  logic [PLW-1:0] cur_cpl,
  input  logic           beyond_table,
  output logic           rsp_valid,
  output logic           rsp_ok,
  output logic           rsp_write,
  output logic [DW-1:0]  rsp_data
);
  localparam int unsigned LO_W   = 16;
  localparam int unsigned HI_W   = 4;
  localparam int unsigned HI_LSB = 16;
  localparam int unsigned SHIFT  = 12;

  attr_t         attr;
  logic          is_code;
  logic          conforming;
  logic          vis_pass;
  logic          rights_type_ok;
  logic          limit_type_ok;
  logic          type_pass;
  logic          in_table;
  logic          grant;
  logic [DW-1:0] limit_val;
  logic [DW-1:0] rights_val;
  logic [DW-1:0] result;
  logic          unused_lo;

  assign attr       = f_attr(desc_hi[31:0]);
  assign is_code    = attr.is_seg && attr.tcode[3];
  assign conforming = is_code && attr.tcode[2];
  assign unused_lo  = ^desc_lo[DW-1:LO_W];

  dq_visibility #(.PLW(PLW)) u_vis (
    .cpl        (cur_cpl),
    .rpl        (sel_rpl),
    .dpl        (PLW'(attr.dpl)),
    .conforming (conforming),
    .visible    (vis_pass)
  );

  dq_type_screen #(.CODE_W(4), .SYS_OK(RIGHTS_SYS)) u_rights_screen (
    .is_seg (attr.is_seg),
    .tcode  (attr.tcode),
    .pass   (rights_type_ok)
  );

  dq_type_screen #(.CODE_W(4), .SYS_OK(LIMIT_SYS)) u_limit_screen (
    .is_seg (attr.is_seg),
    .tcode  (attr.tcode),
    .pass   (limit_type_ok)
  );

  dq_limit_build #(.DW(DW), .LO_W(LO_W), .HI_W(HI_W), .SHIFT(SHIFT)) u_limit (
    .lo_part (desc_lo[LO_W-1:0]),
    .hi_part (desc_hi[HI_LSB+HI_W-1:HI_LSB]),
    .gran    (attr.gran),
    .limit   (limit_val)
  );

  assign rights_val = desc_hi & DW'(RIGHTS_MASK);
  assign type_pass  = (query_e'(query_kind) == Q_LIMIT) ? limit_type_ok : rights_type_ok;
  assign in_table   = !beyond_table;
  assign grant      = req_valid && in_table && vis_pass && type_pass;
  assign result     = (query_e'(query_kind) == Q_LIMIT) ? limit_val : rights_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_write <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= grant;
      rsp_write <= grant;
      rsp_data  <= grant ? result : '0;
    end
  end
endmodule

// File: rtl/dq_query_checker.sv
module dq_query_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        query_kind,
  input logic [31:0] desc_hi,
  input logic [1:0]  sel_rpl,
  input logic [1:0]  cur_cpl,
  input logic        beyond_table,
  input logic        rsp_valid,
  input logic        rsp_ok,
  input logic        rsp_write,
  input logic [31:0] rsp_data
);
  p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_no_spurious_resp_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  p_table_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ok |-> !$past(beyond_table));

  p_visibility_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && !$past(desc_hi[12] && desc_hi[11] && desc_hi[10]))
      |-> ($past(cur_cpl) <= $past(desc_hi[14:13])) && ($past(sel_rpl) <= $past(desc_hi[14:13])));

  p_rights_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && !$past(query_kind)) |-> (rsp_data[7:0] == 8'h00) && (rsp_data[31:24] == 8'h00));

  p_limit_gate_fails_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(query_kind) && $past(!desc_hi[12] && desc_hi[10])) |-> !rsp_ok);

  p_limit_gran_fill_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && $past(query_kind) && $past(desc_hi[23])) |-> (rsp_data[11:0] == 12'hFFF));

  p_fail_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_data == 32'h0) && !rsp_write);

  p_write_needs_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_write |-> (rsp_valid && rsp_ok));

  always_comb begin
    if (!rst_n) begin
      a_reset_quiet_r10: assert (!rsp_valid && !rsp_ok && !rsp_write);
    end
  end
endmodule

bind dq_query_unit dq_query_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .query_kind   (query_kind),
  .desc_hi      (desc_hi),
  .sel_rpl      (sel_rpl),
  .cur_cpl      (cur_cpl),
  .beyond_table (beyond_table),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .rsp_write    (rsp_write),
  .rsp_data     (rsp_data)
);

// File: tb/dq_query_unit_test.sv
`timescale 1ns/1ps
module dq_query_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        query_kind = 1'b0;
  logic [31:0] desc_lo = '0;
  logic [31:0] desc_hi = '0;
  logic [1:0]  sel_rpl = '0;
  logic [1:0]  cur_cpl = '0;
  logic        beyond_table = 1'b0;
  logic        rsp_valid;
  logic        rsp_ok;
  logic        rsp_write;
  logic [31:0] rsp_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] q_data[$];
  logic        q_ok[$];
  int          q_due[$];
  string       q_tag[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dq_query_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .query_kind(query_kind),
    .desc_lo(desc_lo), .desc_hi(desc_hi), .sel_rpl(sel_rpl), .cur_cpl(cur_cpl),
    .beyond_table(beyond_table), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_write(rsp_write), .rsp_data(rsp_data)
  );

  // Independent reference model written from the requirements.
  function automatic void model(input logic kind, input logic [31:0] lo, input logic [31:0] hi,
                                input logic [1:0] rpl, input logic [1:0] cpl, input logic beyond,
                                output logic [31:0] d, output logic ok);
    logic [1:0]  lvl;
    logic        vis;
    logic        tok;
    logic [19:0] lim;
    lvl = (rpl >= cpl) ? rpl : cpl;
    vis = (hi[12] && hi[11] && hi[10]) || (hi[14:13] >= lvl);
    if (hi[12]) tok = 1'b1;
    else if (kind) tok = (hi[11:8] inside {4'd1, 4'd2, 4'd3, 4'd9, 4'd11});
    else tok = (hi[11:8] inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd9, 4'd11, 4'd12});
    ok = !beyond && vis && tok;
    lim = {hi[19:16], lo[15:0]};
    if (!ok) d = 32'h0;
    else if (!kind) d = {8'h00, hi[23:8], 8'h00};
    else if (hi[23]) d = {lim, 12'hFFF};
    else d = {12'h000, lim};
  endfunction

  function automatic logic [31:0] mk_hi(input logic g, input logic [1:0] dpl, input logic seg,
                                        input logic [3:0] t, input logic [3:0] limhi);
    return {8'h5A, g, 3'b101, limhi, 1'b1, dpl, seg, t, 8'hC3};
  endfunction

  task automatic send(input logic kind, input logic [31:0] lo, input logic [31:0] hi,
                      input logic [1:0] rpl, input logic [1:0] cpl, input logic beyond,
                      input string tag);
    logic [31:0] d;
    logic ok;
    @(negedge clk);
    req_valid = 1'b1; query_kind = kind; desc_lo = lo; desc_hi = hi;
    sel_rpl = rpl; cur_cpl = cpl; beyond_table = beyond;
    model(kind, lo, hi, rpl, cpl, beyond, d, ok);
    q_data.push_back(d); q_ok.push_back(ok); q_due.push_back(cyc + 1); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 1'b0;
      desc_hi = 32'hFFFF_FFFF;
    end
  endtask

  // Monitor: pops one expected item per response and checks value and cycle.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && rsp_valid) begin
        checks++;
        if (q_data.size() == 0) begin
          errors++;
          $display("FAIL R1 spurious response: data=%h ok=%b expected no response", rsp_data, rsp_ok);
        end else begin
          logic [31:0] ed;
          logic eo;
          int due;
          string tg;
          ed = q_data.pop_front(); eo = q_ok.pop_front(); due = q_due.pop_front(); tg = q_tag.pop_front();
          if (rsp_data !== ed || rsp_ok !== eo || rsp_write !== eo || cyc != due) begin
            errors++;
            $display("FAIL %s (R1 R9): data=%h ok=%b wr=%b cyc=%0d expected data=%h ok=%b wr=%b cyc=%0d",
                     tg, rsp_data, rsp_ok, rsp_write, cyc, ed, eo, eo, due);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: outputs quiet under reset even with a request applied
    req_valid = 1'b1; query_kind = 1'b1; desc_hi = mk_hi(1'b1, 2'd3, 1'b1, 4'h2, 4'hF);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++;
    if (rsp_valid || rsp_ok || rsp_write || rsp_data != 32'h0) begin
      errors++;
      $display("FAIL R10: valid=%b ok=%b wr=%b data=%h expected 0 0 0 00000000",
               rsp_valid, rsp_ok, rsp_write, rsp_data);
    end
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);

    // R4 rights on a data segment, bits 19:16 set
    send(1'b0, 32'h1234_ABCD, mk_hi(1'b1, 2'd3, 1'b1, 4'h2, 4'hA), 2'd3, 2'd3, 1'b0, "R4 rights data");
    // R2 beyond table on an otherwise valid descriptor
    send(1'b0, 32'h0, mk_hi(1'b0, 2'd3, 1'b1, 4'h2, 4'h0), 2'd0, 2'd0, 1'b1, "R2 beyond table");
    send(1'b1, 32'hFFFF, mk_hi(1'b0, 2'd0, 1'b1, 4'hA, 4'h1), 2'd0, 2'd0, 1'b1, "R2 beyond table limit");
    // R3 visibility
    send(1'b0, 32'h0, mk_hi(1'b0, 2'd0, 1'b1, 4'h2, 4'h0), 2'd0, 2'd3, 1'b0, "R3 cpl above dpl");
    send(1'b0, 32'h0, mk_hi(1'b0, 2'd1, 1'b1, 4'h2, 4'h0), 2'd2, 2'd0, 1'b0, "R3 rpl above dpl");
    send(1'b0, 32'h0, mk_hi(1'b0, 2'd2, 1'b1, 4'h2, 4'h0), 2'd2, 2'd2, 1'b0, "R3 equal levels");
    send(1'b1, 32'h0042, mk_hi(1'b0, 2'd0, 1'b1, 4'hE, 4'h0), 2'd3, 2'd3, 1'b0, "R3 conforming code");
    send(1'b1, 32'h0042, mk_hi(1'b0, 2'd0, 1'b1, 4'hA, 4'h0), 2'd3, 2'd3, 1'b0, "R3 nonconforming code");
    idle(3);
    // R5 and R6: every system type for both queries
    for (int t = 0; t < 16; t++) begin
      send(1'b0, 32'h0000_0067, mk_hi(1'b0, 2'd3, 1'b0, 4'(t), 4'h0), 2'd0, 2'd0, 1'b0, "R5 system type");
      send(1'b1, 32'h0000_0067, mk_hi(1'b0, 2'd3, 1'b0, 4'(t), 4'h0), 2'd0, 2'd0, 1'b0, "R6 system type");
    end
    // R7 and R8 limit expansion
    send(1'b1, 32'hDEAD_BEEF, mk_hi(1'b0, 2'd3, 1'b1, 4'h2, 4'h7), 2'd1, 2'd1, 1'b0, "R7 byte granular");
    send(1'b1, 32'hDEAD_0003, mk_hi(1'b1, 2'd3, 1'b1, 4'h2, 4'h8), 2'd1, 2'd1, 1'b0, "R8 page granular");
    send(1'b1, 32'h0000_FFFF, mk_hi(1'b1, 2'd3, 1'b1, 4'h6, 4'hF), 2'd0, 2'd0, 1'b0, "R8 full limit");
    send(1'b1, 32'hFFFF_0000, mk_hi(1'b1, 2'd3, 1'b1, 4'h2, 4'h0), 2'd0, 2'd0, 1'b0, "R8 zero limit");
    idle(1);
    // Mixed pseudo-random traffic with gaps (R1 R3 R5 R6 R9)
    for (int i = 0; i < 300; i++) begin
      logic [31:0] rl;
      logic [31:0] rh;
      logic [3:0]  rc;
      rl = $urandom; rh = $urandom; rc = 4'($urandom);
      send(rc[0], rl, rh, rc[2:1], 2'($urandom), (rc[3] && rl[5]), "random mix");
      if (rl[31:29] == 3'd0) idle(1);
    end
    idle(4);
    checks++;
    if (q_data.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses: pending=%0d expected 0", q_data.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule